// File: doc/BRIEF.md
# Byte-Lane Staged FIFO Data Port

This block sits between an 8-bit register bus and a serial engine. It exposes one 32-bit data register as four byte lanes, with two 16-entry FIFOs behind it. Writes to lanes 1 to 3 only fill a staging latch. A write to lane 0 pushes the staged upper bytes and the new low byte into the send FIFO as one entry. On the read side, a lane-0 read pops one whole entry from the receive FIFO into a hold register and returns its low byte. Later reads of lanes 1 to 3 return the other bytes of that held entry. Software therefore touches lane 0 last when writing and first when reading.

The serial engine takes send entries through a valid/ready pair and delivers received words through a second valid/ready pair. A control write carries two self-clearing strobes, one that empties each FIFO. A status word reports the fill flags and the occupancy counts. Received data is masked to the frame length in use, so bits above that length always read as zero.

Top module: `lane_fifo_port`

## Requirements
- R1: After reset, `status` is 0x00000002 (send not full, everything else zero), `rdata` is 0, `tx_valid` is 0 and `rx_ready` is 1.
- R2: A bus write to lane 1, 2 or 3 latches that byte into bits [15:8], [23:16] or [31:24] of the staging register and does not change the send count.
- R3: A bus write to lane 0 pushes {staged bytes 3..1, written byte} into the send FIFO. Entries leave on `tx_data` in first-in first-out order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R4: A lane-0 write while the send FIFO holds 16 entries is dropped. The count stays 16 and the stored entries are unchanged.
- R5: A bus read of lane 0 pops the head of the receive FIFO. Its bits [7:0] appear on `rdata` in the cycle after the read, and the receive count drops by one.
- R6: A bus read of lane 1, 2 or 3 returns bits [15:8], [23:16] or [31:24] of the entry most recently popped by a lane-0 read, in the cycle after the read, and does not pop.
- R7: A lane-0 read while the receive FIFO is empty returns 0, leaves the count at 0, and makes later upper-lane reads return 0.
- R8: A popped entry is masked to its low `len_m1`+1 bits, using the `len_m1` value at the moment of the pop.
- R9: A control write with bit 2 set empties the receive FIFO, and one with bit 3 set empties the send FIFO. Both counts read 0 in the next cycle. A control write with neither bit set changes nothing.
- R10: `status` bit 0 is set when the receive FIFO holds 16 entries. Bit 1 is set when the send FIFO holds fewer than 16. Bits [8:4] hold the receive count and bits [16:12] the send count, each updated in the cycle after the access that changes it.
- R11: `rx_ready` is low exactly when the receive FIFO holds 16 entries. A word offered while it is low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_we | input | 1 | Bus write to the data register |
| dat_re | input | 1 | Bus read of the data register |
| lane | input | 2 | Byte lane of the data access |
| wdata | input | 8 | Bus write byte |
| rdata | output | 8 | Bus read byte, valid the cycle after `dat_re` |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control byte: bit 2 empties receive, bit 3 empties send |
| len_m1 | input | 5 | Frame length in bits minus one |
| status | output | 32 | Fill flags and occupancy counts |
| tx_valid | output | 1 | Send FIFO holds an entry |
| tx_data | output | 32 | Head entry of the send FIFO |
| tx_ready | input | 1 | Engine takes the head entry |
| rx_valid | input | 1 | Engine offers a received word |
| rx_data | input | 32 | Received word |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
Every result here lands one clock edge after the access that causes it. A pushed entry shows on `tx_data` and in the send count at the next edge. A lane-0 read puts the popped byte on `rdata` and the new receive count in `status` at the next edge. An upper-lane read after a pop needs the hold register, which is itself loaded one edge after the pop. The bench drives each access on a falling edge, holds it for one rising edge, and samples on the following falling edge, so every check reads the value from exactly one edge after its stimulus. Drop, no-pop and clear cases are checked through the status counts and through the data that later leaves the FIFO.

// File: rtl/lane_fifo_port.sv
module lane_fifo_port #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dat_we,
  input  logic        dat_re,
  input  logic [1:0]  lane,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  input  logic [4:0]  len_m1,
  output logic [31:0] status,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [31:0] rx_data,
  output logic        rx_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   tx_mem [DEPTH];
  logic [31:0]   rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:8]   stage;
  logic [31:0]   hold;

  wire clr_rx  = ctl_we && ctl_wdata[2];
  wire clr_tx  = ctl_we && ctl_wdata[3];
  wire tx_full = (tx_cnt == CW'(DEPTH));
  wire rx_full = (rx_cnt == CW'(DEPTH));
  wire rx_emp  = (rx_cnt == '0);
  wire tx_push = dat_we && (lane == 2'd0) && !tx_full && !clr_tx;
  wire tx_pop  = tx_valid && tx_ready && !clr_tx;
  wire rx_push = rx_valid && rx_ready && !clr_rx;
  wire rx_pop  = dat_re && (lane == 2'd0) && !rx_emp && !clr_rx;

  wire [31:0] len_mask = 32'hFFFF_FFFF >> (5'd31 - len_m1);
  wire [31:0] head_rx  = rx_emp ? 32'h0 : (rx_mem[rx_rp] & len_mask);

  assign tx_valid = (tx_cnt != '0);
  assign tx_data  = tx_mem[tx_rp];
  assign rx_ready = !rx_full;
  assign status   = {15'b0, 5'(tx_cnt), 3'b0, 5'(rx_cnt), 2'b0, !tx_full, rx_full};

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= {stage, wdata};
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == AW'(DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == AW'(DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == AW'(DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == AW'(DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      hold  <= '0;
      rdata <= '0;
    end else begin
      if (dat_we && lane != 2'd0) stage[8*lane +: 8] <= wdata;
      if (dat_re) begin
        if (lane == 2'd0) begin
          hold  <= head_rx;
          rdata <= head_rx[7:0];
        end else begin
          rdata <= hold[8*lane +: 8];
        end
      end
    end
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH)); // R4
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && lane == 2'd0 && tx_full && !tx_ready && !ctl_we) |=> tx_full); // R4
  AST_UPPER_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && lane != 2'd0 && !rx_valid && !ctl_we) |=> $stable(rx_cnt)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && lane == 2'd0 && rx_emp && !rx_valid) |=> (rx_cnt == '0 && rdata == 8'h0)); // R7
  AST_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[3]) |=> !tx_valid); // R9
  AST_CLR_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2]) |=> rx_ready && rx_emp); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !dat_re && !ctl_we) |=> !rx_ready); // R11
endmodule

// File: tb/sim_lane_fifo_port.sv
module sim_lane_fifo_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        dat_we = 0, dat_re = 0, ctl_we = 0, tx_ready = 0, rx_valid = 0;
  logic [1:0]  lane = 0;
  logic [7:0]  wdata = 0, ctl_wdata = 0;
  logic [4:0]  len_m1 = 5'd31;
  logic [31:0] rx_data = 0;
  logic [7:0]  rdata;
  logic [31:0] status, tx_data;
  logic        tx_valid, rx_ready;
  int          n_run = 0, n_fail = 0;

  lane_fifo_port u0 (.clk, .rst_n, .dat_we, .dat_re, .lane, .wdata, .rdata,
    .ctl_we, .ctl_wdata, .len_m1, .status, .tx_valid, .tx_data, .tx_ready,
    .rx_valid, .rx_data, .rx_ready);

  always #4 clk = ~clk;

  localparam logic [31:0] VW [6] = '{32'h1234_5678, 32'hA5C3_0F1E, 32'hDEAD_BEEF,
                                     32'h0000_01FF, 32'hFFFF_FFFF, 32'h8000_0001};
  localparam logic [4:0]  VL [6] = '{5'd31, 5'd7, 5'd15, 5'd8, 5'd2, 5'd23};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] l, input logic [7:0] d);
    dat_we = 1; lane = l; wdata = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] l);
    dat_re = 1; lane = l;
    @(negedge clk); dat_re = 0;
  endtask

  task automatic push_word(input logic [31:0] w);
    bus_wr(2'd3, w[31:24]); bus_wr(2'd2, w[23:16]); bus_wr(2'd1, w[15:8]); bus_wr(2'd0, w[7:0]);
  endtask

  task automatic ctl(input logic [7:0] d);
    ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic feed(input logic [31:0] w);
    rx_valid = 1; rx_data = w;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic take;
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  function automatic logic [31:0] msk(input logic [4:0] l);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (i <= l) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] e;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 32'h2);
    chk("R1 rdata", {24'h0, rdata}, 32'h0);
    chk("R1 tx_valid/rx_ready", {30'h0, tx_valid, rx_ready}, 32'h1);

    for (int k = 0; k < 6; k++) begin
      bus_wr(2'd3, VW[k][31:24]); bus_wr(2'd2, VW[k][23:16]); bus_wr(2'd1, VW[k][15:8]);
      chk("R2 no push on upper lanes", status[16:12], 0);
      bus_wr(2'd0, VW[k][7:0]);
      chk("R10 send count after push", status[16:12], 1);
      chk("R3 assembled entry", tx_data, VW[k]);
      take;
      chk("R3 engine pop", status[16:12], 0);
      len_m1 = VL[k];
      feed(VW[k]);
      chk("R10 receive count", status[8:4], 1);
      e = VW[k] & msk(VL[k]);
      bus_rd(2'd0);
      chk("R5/R8 low byte", rdata, e[7:0]);
      chk("R5 count after pop", status[8:4], 0);
      bus_rd(2'd3); chk("R6/R8 lane 3", rdata, e[31:24]);
      bus_rd(2'd1); chk("R6/R8 lane 1", rdata, e[15:8]);
      bus_rd(2'd2); chk("R6/R8 lane 2", rdata, e[23:16]);
    end
    len_m1 = 5'd31;

    for (int i = 0; i < 16; i++) push_word(32'hC000_0000 + i);
    chk("R4 full count", status[16:12], 16);
    chk("R10 not-full flag clear", status[1], 0);
    push_word(32'hBAD0_BAD0);
    chk("R4 dropped push", status[16:12], 16);
    chk("R4 head unchanged", tx_data, 32'hC000_0000);
    take;
    chk("R3 FIFO order", tx_data, 32'hC000_0001);
    ctl(8'h00);
    chk("R9 null control", status[16:12], 15);
    ctl(8'h08);
    chk("R9 send clear", status[16:12], 0);
    chk("R9 tx_valid after clear", tx_valid, 0);

    for (int i = 0; i < 16; i++) feed(32'h5500_0000 + i);
    chk("R11 rx_ready low", rx_ready, 0);
    chk("R10 receive full flag", status[0], 1);
    feed(32'hFFFF_0000);
    chk("R11 offered word refused", status[8:4], 16);
    bus_rd(2'd2);
    chk("R6 upper read no pop", status[8:4], 16);
    bus_rd(2'd0);
    chk("R5 pop from full", rdata, 8'h00);
    chk("R5 count", status[8:4], 15);
    bus_rd(2'd0);
    chk("R5 second entry", rdata, 8'h01);
    ctl(8'h04);
    chk("R9 receive clear", status[8:4], 0);
    chk("R9 send untouched", status[16:12], 0);

    bus_rd(2'd0);
    chk("R7 empty read data", rdata, 8'h00);
    chk("R7 empty read count", status[8:4], 0);
    bus_rd(2'd3);
    chk("R7 upper after empty pop", rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule